// File: doc/BRIEF.md
# Vertical Blanking Line Controller

This block sits beside the line counter of a 4:2:2 digital video output path for an interlaced raster of either 525 or 625 lines. For every sample it takes the current 1-based line number, a flag that says whether the sample lies in the second half of the line, and a flag that marks luma sample positions. From these it derives two separate vertical regions. The first is the V flag that a timing-reference code generator places in its EAV/SAV words. That region is fixed for the chosen raster, and a standard-select bit chooses between two variants of it. The second is a blanking window whose length can be programmed. Inside that window the sample stream is replaced by black. When pass-through is enabled, luma is instead forwarded unchanged so that data carried on those lines can be recovered downstream. A setup-permit output tells the pedestal stage when it may apply setup.

An 8-bit configuration word is written into a shadow register. It is copied into the working register only on a line-start strobe, so a write never changes the outputs in the middle of a line. Every output is registered and follows its inputs by one clock.

Top module: `vbiLineCtrl`

## Requirements
- R1: After reset the working configuration is 0x14 (window length 20, pass-through off, standard select 0, half-line setup bit 0), and vFlag, vbiActive, setupAllow and sampleOut all read 0.
- R2: With the 525-line raster and standard select (config bit 6) at 0, vFlag is 1 on lines 1 to 9 and 264 to 272, and 0 on every other valid line.
- R3: With the 525-line raster and standard select at 1, vFlag is 1 on lines 1 to 19 and 264 to 282, and 0 on every other valid line.
- R4: With the 625-line raster, vFlag is 1 on lines 1 to 22, 311 to 335 and 624 to 625, and 0 on lines 23 to 310 and 336 to 623. The standard-select bit has no effect here.
- R5: The V flag does not depend on the window length (config bits 4:0), on pass-through or on the half-line setup bit.
- R6: In both rasters, with window length N (config bits 4:0), vbiActive is 1 on lines 1 to N of the first field.
- R7: In the 525-line second field with N of at least 1, the window covers the second half of line 263, every full line from 264 to N+262, and the first half of line N+263. With the default length this is line 263.5 up to line 283.5. With N equal to 0, no second-field window exists.
- R8: In the 625-line second field, vbiActive is 1 on lines 311 to N+311 inclusive.
- R9: Inside the window with pass-through (config bit 7) at 0, sampleOut is 0x10 on luma positions (lumaPhase=1) and 0x80 on chroma positions (lumaPhase=0).
- R10: Inside the window with pass-through at 1, luma positions carry sampleIn unchanged and chroma positions carry 0x80. Outside the window, sampleOut always equals sampleIn.
- R11: setupAllow is 0 throughout the window. In the 525-line raster with N of at least 1, the second half of line N+263 takes the value of the half-line setup bit (config bit 5). Everywhere else setupAllow is 1.
- R12: A line number of 0, or above the line count of the selected raster, forces vFlag and vbiActive to 0.
- R13: Every output reflects the inputs of the previous clock. A configuration write takes effect only at the clock after a lineStart strobe. When lineStart and a write arrive in the same cycle, the value written earlier is the one that is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sys625 | input | 1 | 1 selects the 625-line raster, 0 selects the 525-line raster |
| lineNum | input | 10 | Current line number, 1-based |
| secondHalf | input | 1 | 1 when the sample lies in the second half of the line |
| lineStart | input | 1 | Start-of-line strobe; copies the shadow configuration into the working register |
| cfgWrEn | input | 1 | Write strobe for the shadow configuration |
| cfgWrData | input | 8 | Configuration: bit 7 pass-through, bit 6 standard select, bit 5 half-line setup, bits 4:0 window length |
| lumaPhase | input | 1 | 1 on Y sample positions, 0 on Cb/Cr positions |
| sampleIn | input | 8 | Incoming 4:2:2 sample |
| vFlag | output | 1 | V flag for the timing reference code |
| vbiActive | output | 1 | High inside the programmed blanking window |
| setupAllow | output | 1 | Permits the pedestal (setup) adjustment |
| sampleOut | output | 8 | Outgoing sample after blanking substitution |

## Verification
The hardest condition to reach is the half-line edge of the 525-line second-field window. It involves line 263 with secondHalf set, and line N+263 on both halves, where setupAllow switches to the half-line setup bit. That edge only lines up with a programmed length after a write followed by a lineStart. To get there, the stimulus keeps many line numbers clustered around 255 to 300 and toggles secondHalf at random. It rewrites the configuration often with random lengths, including 0, 1 and 31. Directed steps also walk each boundary line for the default length and hold back lineStart to confirm that a pending write stays inactive.

// File: rtl/vbiPkg.sv
`timescale 1ns/1ps
package vbiPkg;
  localparam int LINE_W = 10;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 5;

  typedef struct packed {
    logic             passThru;
    logic             stdAlt;
    logic             halfSu;
    logic [LEN_W-1:0] len;
  } vbiCfgT;

  localparam vbiCfgT CFG_RST = 8'h14;

  // strobes from control to datapath
  typedef struct packed {
    logic vRegion;
    logic inWindow;
    logic passThru;
    logic setupOk;
  } vbiStbT;
endpackage

// File: rtl/vbiCtrl.sv
`timescale 1ns/1ps
module vbiCtrl
  import vbiPkg::*;
#(
  parameter int LINES_A = 525,
  parameter int LINES_B = 625
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sys625,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              secondHalf,
  input  logic              lineStart,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output vbiStbT            stb
);
  typedef logic [LINE_W-1:0] lineT;

  // 525-line raster landmarks
  localparam lineT A_MAX      = lineT'(LINES_A);
  localparam lineT A_F2_HALF  = lineT'((LINES_A + 1) / 2);   // 263
  localparam lineT A_F2_FULL  = lineT'((LINES_A + 1) / 2 + 1);
  localparam lineT A_V0_END   = lineT'(9);
  localparam lineT A_V1_END   = lineT'(19);
  localparam lineT A_V0_F2END = lineT'((LINES_A + 1) / 2 + 9);
  localparam lineT A_V1_F2END = lineT'((LINES_A + 1) / 2 + 19);
  // 625-line raster landmarks
  localparam lineT B_MAX      = lineT'(LINES_B);
  localparam lineT B_F2       = lineT'((LINES_B - 3) / 2);   // 311
  localparam lineT B_V_F1END  = lineT'(22);
  localparam lineT B_V_F2END  = lineT'((LINES_B - 3) / 2 + 24);
  localparam lineT B_TAIL     = lineT'(LINES_B - 1);
  localparam lineT ONE        = lineT'(1);

  vbiCfgT shadowCfg, actCfg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= CFG_RST;
      actCfg    <= CFG_RST;
    end else begin
      if (cfgWrEn)   shadowCfg <= vbiCfgT'(cfgWrData);
      if (lineStart) actCfg    <= shadowCfg;
    end
  end

  lineT lenExt, aEndLine, bEndLine;
  logic lineValid, lenNz;
  logic vA, vB, winF1, winA2, winB2, halfAfter;

  always_comb begin
    lenExt    = lineT'(actCfg.len);
    lenNz     = (actCfg.len != '0);
    aEndLine  = A_F2_HALF + lenExt;
    bEndLine  = B_F2 + lenExt;
    lineValid = (lineNum >= ONE) && (lineNum <= (sys625 ? B_MAX : A_MAX));

    vA = actCfg.stdAlt
       ? ((lineNum <= A_V1_END) || (lineNum >= A_F2_FULL && lineNum <= A_V1_F2END))
       : ((lineNum <= A_V0_END) || (lineNum >= A_F2_FULL && lineNum <= A_V0_F2END));
    vB = (lineNum <= B_V_F1END) || (lineNum >= B_F2 && lineNum <= B_V_F2END)
       || (lineNum >= B_TAIL);

    winF1 = (lineNum <= lenExt);
    winA2 = lenNz && (((lineNum == A_F2_HALF) && secondHalf)
                   || ((lineNum >= A_F2_FULL) && (lineNum < aEndLine))
                   || ((lineNum == aEndLine) && !secondHalf));
    winB2 = (lineNum >= B_F2) && (lineNum <= bEndLine);
    halfAfter = !sys625 && lenNz && (lineNum == aEndLine) && secondHalf;

    stb.vRegion  = lineValid && (sys625 ? vB : vA);
    stb.inWindow = lineValid && (winF1 || (sys625 ? winB2 : winA2));
    stb.passThru = actCfg.passThru;
    stb.setupOk  = stb.inWindow ? 1'b0 : (halfAfter ? actCfg.halfSu : 1'b1);
  end
endmodule

// File: rtl/vbiDatapath.sv
`timescale 1ns/1ps
module vbiDatapath
  import vbiPkg::*;
#(
  parameter int              DW      = DATA_W,
  parameter logic [DW-1:0]   BLACK_Y = DW'(8'h10),
  parameter logic [DW-1:0]   BLACK_C = DW'(8'h80)
) (
  input  logic          clk,
  input  logic          rstN,
  input  vbiStbT        stb,
  input  logic          lumaPhase,
  input  logic [DW-1:0] sampleIn,
  output logic          vFlag,
  output logic          vbiActive,
  output logic          setupAllow,
  output logic [DW-1:0] sampleOut
);
  logic [DW-1:0] blackVal, nextSample;

  always_comb begin
    blackVal = lumaPhase ? BLACK_Y : BLACK_C;
    if (!stb.inWindow)
      nextSample = sampleIn;
    else if (stb.passThru && lumaPhase)
      nextSample = sampleIn;
    else
      nextSample = blackVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vFlag      <= 1'b0;
      vbiActive  <= 1'b0;
      setupAllow <= 1'b0;
      sampleOut  <= '0;
    end else begin
      vFlag      <= stb.vRegion;
      vbiActive  <= stb.inWindow;
      setupAllow <= stb.setupOk;
      sampleOut  <= nextSample;
    end
  end
endmodule

// File: rtl/vbiLineCtrl.sv
`timescale 1ns/1ps
module vbiLineCtrl
  import vbiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sys625,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              secondHalf,
  input  logic              lineStart,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  input  logic              lumaPhase,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              vFlag,
  output logic              vbiActive,
  output logic              setupAllow,
  output logic [DATA_W-1:0] sampleOut
);
  vbiStbT ctrlStb;

  vbiCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sys625(sys625), .lineNum(lineNum),
    .secondHalf(secondHalf), .lineStart(lineStart), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .stb(ctrlStb)
  );

  vbiDatapath u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .lumaPhase(lumaPhase),
    .sampleIn(sampleIn), .vFlag(vFlag), .vbiActive(vbiActive),
    .setupAllow(setupAllow), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/vbiLineCtrlChk.sv
`timescale 1ns/1ps
module vbiLineCtrlChk
  import vbiPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sys625,
  input logic [LINE_W-1:0] lineNum,
  input logic              lumaPhase,
  input logic              cfgPass,
  input logic              vFlag,
  input logic              vbiActive,
  input logic              setupAllow,
  input logic [DATA_W-1:0] sampleOut
);
  localparam logic [LINE_W-1:0] MAX_A = LINE_W'(525);
  localparam logic [LINE_W-1:0] MAX_B = LINE_W'(625);
  localparam logic [LINE_W-1:0] TAIL_B = LINE_W'(624);
  localparam logic [LINE_W-1:0] FIRST = LINE_W'(1);

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum == '0 || lineNum > (sys625 ? MAX_B : MAX_A)) |=> (!vFlag && !vbiActive)); // R12
  AST_WINDOW_NO_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    vbiActive |-> !setupAllow); // R11
  AST_BLACK_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (vbiActive && !$past(cfgPass)) |-> (sampleOut == ($past(lumaPhase) ? 8'h10 : 8'h80))); // R9
  AST_PASS_CHROMA: assert property (@(posedge clk) disable iff (!rstN)
    (vbiActive && $past(cfgPass) && !$past(lumaPhase)) |-> (sampleOut == 8'h80)); // R10
  AST_FIRST_LINE_V: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum == FIRST) |=> vFlag); // R2
  AST_TAIL_V_625: assert property (@(posedge clk) disable iff (!rstN)
    (sys625 && lineNum == TAIL_B) |=> vFlag); // R4
endmodule

bind vbiLineCtrl vbiLineCtrlChk u_chk (
  .clk(clk), .rstN(rstN), .sys625(sys625), .lineNum(lineNum),
  .lumaPhase(lumaPhase), .cfgPass(ctrlStb.passThru), .vFlag(vFlag),
  .vbiActive(vbiActive), .setupAllow(setupAllow), .sampleOut(sampleOut)
);

// File: tb/tb_vbiLineCtrl.sv
`timescale 1ns/1ps
module tb_vbiLineCtrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sys625 = 1'b0;
  logic [9:0] lineNum = '0;
  logic       secondHalf = 1'b0;
  logic       lineStart = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic       lumaPhase = 1'b0;
  logic [7:0] sampleIn = '0;
  logic       vFlag, vbiActive, setupAllow;
  logic [7:0] sampleOut;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;
  logic [7:0] mShadow = 8'h14;
  logic [7:0] mActive = 8'h14;

  always #4 clk = ~clk;

  vbiLineCtrl dut (.*);

  function automatic bit expV(bit s, bit std, int ln);
    if (ln < 1 || ln > (s ? 625 : 525)) return 0;
    if (s) return (ln <= 22) || (ln >= 311 && ln <= 335) || (ln >= 624);
    if (std) return (ln <= 19) || (ln >= 264 && ln <= 282);
    return (ln <= 9) || (ln >= 264 && ln <= 272);
  endfunction

  function automatic bit expWin(bit s, int len, int ln, bit half);
    int pos;
    if (ln < 1 || ln > (s ? 625 : 525)) return 0;
    if (ln <= len) return 1;
    if (s) return (ln >= 311) && (ln <= 311 + len);
    if (len == 0) return 0;
    pos = 2 * ln + int'(half);           // position in half-lines
    return (pos >= 527) && (pos < 2 * (263 + len) + 1);
  endfunction

  function automatic bit expSetup(bit s, logic [7:0] c, int ln, bit half);
    int len = int'(c[4:0]);
    if (expWin(s, len, ln, half)) return 0;
    if (!s && len != 0 && ln == 263 + len && half) return c[5];
    return 1;
  endfunction

  function automatic logic [7:0] expSample(bit win, bit pass, bit luma, logic [7:0] din);
    if (!win) return din;
    if (pass && luma) return din;
    return luma ? 8'h10 : 8'h80;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h (sys625=%0d line=%0d half=%0d cfg=%0h)",
               req, what, act, exp, sys625, lineNum, secondHalf, mActive);
    end
  endtask

  // one clock: drive, predict from model, sample after the edge, update model
  task automatic step(bit s, int ln, bit half, bit ls, bit wr, logic [7:0] wd,
                      bit luma, logic [7:0] din, string vTag, string wTag);
    bit eV, eW, eSu;
    logic [7:0] eS;
    int len;
    sys625 = s; lineNum = 10'(ln); secondHalf = half; lineStart = ls;
    cfgWrEn = wr; cfgWrData = wd; lumaPhase = luma; sampleIn = din;
    len = int'(mActive[4:0]);
    eV  = expV(s, mActive[6], ln);
    eW  = expWin(s, len, ln, half);
    eSu = expSetup(s, mActive, ln, half);
    eS  = expSample(eW, mActive[7], luma, din);
    @(posedge clk); #1;
    check(vTag, "vFlag", int'(vFlag), int'(eV));
    check(wTag, "vbiActive", int'(vbiActive), int'(eW));
    check("R11", "setupAllow", int'(setupAllow), int'(eSu));
    check(eW ? (mActive[7] ? "R10" : "R9") : "R10", "sampleOut", int'(sampleOut), int'(eS));
    if (ls) mActive = mShadow;
    if (wr) mShadow = wd;
    @(negedge clk);
  endtask

  function automatic string vTagOf(bit s, bit std, int ln);
    if (ln < 1 || ln > (s ? 625 : 525)) return "R12";
    if (s) return "R4";
    return std ? "R3" : "R2";
  endfunction

  function automatic string wTagOf(bit s, int ln);
    if (ln < 1 || ln > (s ? 625 : 525)) return "R12";
    if (ln <= 31) return "R6";
    return s ? "R8" : "R7";
  endfunction

  task automatic walk(bit s, int ln, bit half, logic [7:0] din);
    step(s, ln, half, 0, 0, 8'h00, din[0], din, vTagOf(s, mActive[6], ln), wTagOf(s, ln));
  endtask

  task automatic loadCfg(logic [7:0] c);
    step(0, 100, 0, 0, 1, c, 0, 8'h55, "R13", "R13");
    step(0, 100, 0, 1, 0, 8'h00, 1, 8'h56, "R13", "R13");
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check("R1", "reset vFlag", int'(vFlag), 0);
    check("R1", "reset vbiActive", int'(vbiActive), 0);
    check("R1", "reset setupAllow", int'(setupAllow), 0);
    check("R1", "reset sampleOut", int'(sampleOut), 0);
    rstN = 1'b1;

    // R1: default length 20 on the first field edge
    step(0, 20, 0, 0, 0, 8'h00, 1, 8'hA5, "R1", "R1");
    step(0, 21, 0, 0, 0, 8'h00, 1, 8'hA5, "R1", "R1");
    // R7: half-line edges with default length
    walk(0, 263, 0, 8'h33); walk(0, 263, 1, 8'h34);
    walk(0, 283, 0, 8'h35); walk(0, 283, 1, 8'h36);
    // R11: half-line setup bit drives second half of line 283
    loadCfg(8'h34);
    walk(0, 283, 1, 8'h37); walk(0, 283, 0, 8'h38);

    // R13: pending write is not applied without lineStart
    step(0, 50, 0, 0, 1, 8'h1F, 1, 8'h99, "R2", "R13");
    step(0, 25, 0, 0, 0, 8'h00, 1, 8'h99, "R2", "R13");
    // R13: same-cycle write and lineStart applies older value (0x1F)
    step(0, 50, 0, 1, 1, 8'h02, 1, 8'h99, "R2", "R13");
    step(0, 25, 0, 0, 0, 8'h00, 1, 8'h99, "R2", "R13");

    // R5: V flag unchanged by length 31 and pass-through
    loadCfg(8'h9F);
    walk(0, 10, 0, 8'h42); walk(0, 273, 1, 8'h43);
    walk(1, 23, 0, 8'h44); walk(1, 336, 0, 8'h45);
    // R10: pass-through luma and chroma inside the window
    walk(0, 5, 0, 8'h61); walk(0, 5, 1, 8'h62);
    // R8 and R12 corners
    walk(1, 342, 0, 8'h70); walk(1, 343, 0, 8'h71);
    walk(1, 0, 0, 8'h72); walk(0, 526, 0, 8'h73); walk(1, 626, 1, 8'h74);
    walk(1, 625, 0, 8'h75);
    // R7: zero length gives no window
    loadCfg(8'h00);
    walk(0, 263, 1, 8'h11); walk(1, 311, 0, 8'h12); walk(0, 1, 0, 8'h13);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int ln;
      int pick = $urandom_range(0, 4);
      bit s = $urandom_range(0, 1) != 0;
      bit wr = $urandom_range(0, 9) == 0;
      bit ls = $urandom_range(0, 5) == 0;
      logic [7:0] wd = 8'($urandom);
      case (pick)
        0: ln = $urandom_range(0, 640);
        1: ln = $urandom_range(0, 35);
        2: ln = $urandom_range(255, 300);
        3: ln = $urandom_range(305, 345);
        default: ln = $urandom_range(520, 630);
      endcase
      if ($urandom_range(0, 7) == 0) wd[4:0] = ($urandom_range(0, 1) != 0) ? 5'd0 : 5'd31;
      step(s, ln, $urandom_range(0, 1) != 0, ls, wr, wd, $urandom_range(0, 1) != 0,
           8'($urandom), vTagOf(s, mActive[6], ln), wTagOf(s, ln));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule